// File: doc/BRIEF.md
# Transactional Conflict Detector

This block watches the memory accesses of several hardware threads, some of which run speculative transactions, and finds the accesses that break transactional isolation. Each transaction holds a speculation ID, which a start command binds to an owning thread and a start timestamp. Each tracked 128-byte line keeps, for every speculation ID, a mask of the 8-byte sectors it has read and a mask of those it has written. A new access is compared with these masks. An overlap with another live transaction, where at least one side writes, is a conflict. A plain store to data that a live transaction holds is also a conflict.

On a conflict, the detector sets bits in the conflict register of each thread involved. It raises that thread's interrupt when interrupts are enabled, and for conflicts between transactions it reports which one should survive: the one that started first. Software clears a thread's register through a clear port. Invalidating a speculation ID removes its footprint and withdraws the conflict bits that name it, so the other party can still commit. Tracking is fine-grained while at most two threads share a line. When a third thread touches the line, tracking falls back to the two 64-byte halves. The access address is given in 8-byte units: the upper bits select the line and the low four bits select the sector.

Top module: `txn_conflict_detector`

## Requirements
- R1: After reset every conflict register is zero, every interrupt is low and `arb_valid` is low.
- R2: A transactional access by live ID A conflicts with live ID B (B ≠ A) when A writes a sector that B has read or written, or when A reads a sector that B has written. Bit B is then set in the register of A's owner and bit A in the register of B's owner. A read that meets only reads causes no conflict.
- R3: Repeated reads and writes by the same speculation ID never set any conflict bit.
- R4: A non-transactional write to a sector that a live ID has read or written sets bit NUM_IDS (bit 4 by default) in that ID's owner's register. Non-transactional reads change no register.
- R5: While at most two distinct threads have made transactional accesses to a line, that line is tracked per 8-byte sector: accesses to different sectors never conflict.
- R6: Once a third distinct thread accesses a line, that access and all later ones on the line are tracked per 64-byte half (sector bit 3). Accesses in the same half then conflict as if they touched the same sector, and the two halves stay independent.
- R7: Invalidating ID X clears bit X in every conflict register in the next cycle and drops X's footprint, so later accesses by others to X's sectors do not conflict with X.
- R8: `irq[t]` is high exactly when `irq_en` is high and thread t's conflict register is non-zero. With `irq_en` low, conflicts are still recorded in the register.
- R9: One cycle after a transactional access that causes a conflict, `arb_valid` pulses for one cycle. `arb_winner` is then the involved ID with the smallest start timestamp, and the lower ID when timestamps are equal. Accesses that cause no conflict leave `arb_valid` low.
- R10: A clear request zeroes the selected thread's conflict register in the next cycle.
- R11: A transactional access by an ID that has not been started is ignored: it records nothing and raises no conflict.
- R12: When every footprint on a line has been invalidated, the line forgets its thread history and returns to 8-byte tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 1 | Enables conflict interrupts |
| acc_valid | input | 1 | Access present this cycle |
| acc_thread | input | 2 | Issuing thread |
| acc_id | input | 2 | Speculation ID of a transactional access |
| acc_addr | input | 6 | Address in 8-byte units: line index above, sector in bits 3:0 |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_txn | input | 1 | 1 for a transactional access |
| start_valid | input | 1 | Start a transaction |
| start_thread | input | 2 | Owner thread of the started ID |
| start_id | input | 2 | Speculation ID being started |
| start_time | input | 16 | Start timestamp (smaller is older) |
| inval_valid | input | 1 | Invalidate a speculation ID |
| inval_id | input | 2 | ID being invalidated |
| clr_valid | input | 1 | Clear a conflict register |
| clr_thread | input | 2 | Thread whose register is cleared |
| conf_flat | output | 20 | Conflict registers, thread t at bits [t*5 +: 5]; bit i < 4 names ID i, bit 4 marks a plain store |
| irq | output | 4 | Per-thread conflict interrupt |
| arb_valid | output | 1 | Arbitration result valid |
| arb_winner | output | 2 | Speculation ID that should survive |

## Verification
The bound checker watches, on every cycle, the rules that relate a single event to the next state. An invalidate withdraws its ID's bits everywhere, a clear empties a register, and a plain read leaves all registers untouched. Interrupts stay silent while disabled, an arbitration pulse only follows a transactional access, and reset leaves everything clean. Only the bench's scenarios can show the conflict decisions themselves: which read/write pairings collide on the same or a different sector, the collapse to half-line tracking when a third thread arrives and its return once the line empties, the oldest-first arbitration with its tie rule, and the silence for an unstarted ID.

// File: rtl/txc_pkg.sv
package txc_pkg;

    localparam int SECTORS    = 16;
    localparam int SEC_W      = 4;
    localparam int HALF_SECS  = SECTORS / 2;

    typedef logic [SECTORS-1:0] sec_mask_t;

    typedef struct packed {
        logic      coarse;
        sec_mask_t span;
    } footprint_t;

    function automatic sec_mask_t half_span(input logic [SEC_W-1:0] sec);
        return sec[SEC_W-1] ? {{HALF_SECS{1'b1}}, {HALF_SECS{1'b0}}}
                            : {{HALF_SECS{1'b0}}, {HALF_SECS{1'b1}}};
    endfunction

    function automatic sec_mask_t fold_halves(input sec_mask_t m);
        return {{HALF_SECS{|m[SECTORS-1:HALF_SECS]}}, {HALF_SECS{|m[HALF_SECS-1:0]}}};
    endfunction

    function automatic footprint_t make_fp(input logic coarse, input logic [SEC_W-1:0] sec);
        footprint_t f;
        f.coarse = coarse;
        f.span   = coarse ? half_span(sec) : (sec_mask_t'(1) << sec);
        return f;
    endfunction

endpackage

// File: rtl/txc_id_table.sv
module txc_id_table #(
    parameter int NUM_IDS     = 4,
    parameter int NUM_THREADS = 4,
    parameter int TS_W        = 16,
    localparam int IW = $clog2(NUM_IDS),
    localparam int TW = $clog2(NUM_THREADS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start_valid,
    input  logic [IW-1:0]                     start_id,
    input  logic [TW-1:0]                     start_thread,
    input  logic [TS_W-1:0]                   start_time,
    input  logic                              inval_valid,
    input  logic [IW-1:0]                     inval_id,
    output logic [NUM_IDS-1:0]                live,
    output logic [NUM_IDS-1:0][TW-1:0]        owner,
    output logic [NUM_IDS-1:0][TS_W-1:0]      stamp
);

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
        always_ff @(posedge clk) begin
            if (rst) begin
                live[i]  <= 1'b0;
                owner[i] <= '0;
                stamp[i] <= '0;
            end else if (inval_valid && inval_id == IW'(i)) begin
                live[i] <= 1'b0;
            end else if (start_valid && start_id == IW'(i)) begin
                live[i]  <= 1'b1;
                owner[i] <= start_thread;
                stamp[i] <= start_time;
            end
        end
    end

endmodule

// File: rtl/txc_line_track.sv
module txc_line_track
    import txc_pkg::*;
#(
    parameter int NUM_IDS     = 4,
    parameter int NUM_THREADS = 4,
    localparam int IW = $clog2(NUM_IDS),
    localparam int TW = $clog2(NUM_THREADS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd,
    input  logic [IW-1:0]        acc_id,
    input  logic [TW-1:0]        acc_thread,
    input  logic                 acc_write,
    input  logic [SEC_W-1:0]     sector,
    input  logic                 inval_valid,
    input  logic [IW-1:0]        inval_id,
    output logic [NUM_IDS-1:0]   q_rd,
    output logic [NUM_IDS-1:0]   q_wr
);

    sec_mask_t [NUM_IDS-1:0] rd_q, wr_q, rd_n, wr_n;
    logic [NUM_THREADS-1:0]  seen_q, seen_acc, seen_n;
    logic                    coarse_q, coarse_n, coarse_eff, any_left;
    footprint_t              fp;

    always_comb begin
        seen_acc   = seen_q | (upd ? (NUM_THREADS'(1) << acc_thread) : '0);
        coarse_eff = coarse_q | (upd && ($countones(seen_acc) > 2));
        fp         = make_fp(coarse_eff, sector);
        any_left   = 1'b0;
        for (int i = 0; i < NUM_IDS; i++) begin
            q_rd[i] = |(rd_q[i] & fp.span);
            q_wr[i] = |(wr_q[i] & fp.span);
            rd_n[i] = (coarse_eff && !coarse_q) ? fold_halves(rd_q[i]) : rd_q[i];
            wr_n[i] = (coarse_eff && !coarse_q) ? fold_halves(wr_q[i]) : wr_q[i];
            if (upd && acc_id == IW'(i)) begin
                if (acc_write) wr_n[i] = wr_n[i] | fp.span;
                else           rd_n[i] = rd_n[i] | fp.span;
            end
            if (inval_valid && inval_id == IW'(i)) begin
                rd_n[i] = '0;
                wr_n[i] = '0;
            end
            any_left = any_left | (|rd_n[i]) | (|wr_n[i]);
        end
        seen_n   = any_left ? seen_acc   : '0;
        coarse_n = any_left ? coarse_eff : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q     <= '0;
            wr_q     <= '0;
            seen_q   <= '0;
            coarse_q <= 1'b0;
        end else begin
            rd_q     <= rd_n;
            wr_q     <= wr_n;
            seen_q   <= seen_n;
            coarse_q <= coarse_n;
        end
    end

endmodule

// File: rtl/txc_oldest_pick.sv
module txc_oldest_pick #(
    parameter int NUM_IDS = 4,
    parameter int TS_W    = 16,
    localparam int IW = $clog2(NUM_IDS)
) (
    input  logic [NUM_IDS-1:0]            cand,
    input  logic [NUM_IDS-1:0][TS_W-1:0]  stamp,
    output logic [IW-1:0]                 winner
);

    logic            found;
    logic [TS_W-1:0] best;

    always_comb begin
        found  = 1'b0;
        best   = '0;
        winner = '0;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (cand[i] && (!found || stamp[i] < best)) begin
                found  = 1'b1;
                best   = stamp[i];
                winner = IW'(i);
            end
        end
    end

endmodule

// File: rtl/txn_conflict_detector.sv
module txn_conflict_detector
    import txc_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int NUM_IDS     = 4,
    parameter int NUM_LINES   = 4,
    parameter int TS_W        = 16,
    localparam int TW     = $clog2(NUM_THREADS),
    localparam int IW     = $clog2(NUM_IDS),
    localparam int LW     = $clog2(NUM_LINES),
    localparam int AW     = LW + SEC_W,
    localparam int CW     = NUM_IDS + 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        irq_en,
    input  logic                        acc_valid,
    input  logic [TW-1:0]               acc_thread,
    input  logic [IW-1:0]               acc_id,
    input  logic [AW-1:0]               acc_addr,
    input  logic                        acc_write,
    input  logic                        acc_txn,
    input  logic                        start_valid,
    input  logic [TW-1:0]               start_thread,
    input  logic [IW-1:0]               start_id,
    input  logic [TS_W-1:0]             start_time,
    input  logic                        inval_valid,
    input  logic [IW-1:0]               inval_id,
    input  logic                        clr_valid,
    input  logic [TW-1:0]               clr_thread,
    output logic [NUM_THREADS*CW-1:0]   conf_flat,
    output logic [NUM_THREADS-1:0]      irq,
    output logic                        arb_valid,
    output logic [IW-1:0]               arb_winner
);

    logic [NUM_IDS-1:0]                 live, live_eff, inval_oh, self_oh, others;
    logic [NUM_IDS-1:0][TW-1:0]         owner;
    logic [NUM_IDS-1:0][TS_W-1:0]       stamp;
    logic [NUM_LINES-1:0][NUM_IDS-1:0]  line_rd, line_wr;
    logic [NUM_IDS-1:0]                 sel_rd, sel_wr, tx_hits, st_hits;
    logic [LW-1:0]                      line_idx;
    logic [SEC_W-1:0]                   sector;
    logic                               acc_live, plain_store;
    logic [NUM_THREADS-1:0][CW-1:0]     creg_q, creg_n;
    logic [IW-1:0]                      pick;

    assign line_idx    = acc_addr[AW-1:SEC_W];
    assign sector      = acc_addr[SEC_W-1:0];
    assign inval_oh    = inval_valid ? (NUM_IDS'(1) << inval_id) : '0;
    assign self_oh     = NUM_IDS'(1) << acc_id;
    assign live_eff    = live & ~inval_oh;
    assign acc_live    = acc_valid && acc_txn && live_eff[acc_id];
    assign plain_store = acc_valid && !acc_txn && acc_write;
    assign others      = live_eff & ~self_oh;

    txc_id_table #(
        .NUM_IDS(NUM_IDS), .NUM_THREADS(NUM_THREADS), .TS_W(TS_W)
    ) u_ids (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_id(start_id),
        .start_thread(start_thread), .start_time(start_time),
        .inval_valid(inval_valid), .inval_id(inval_id),
        .live(live), .owner(owner), .stamp(stamp)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        txc_line_track #(
            .NUM_IDS(NUM_IDS), .NUM_THREADS(NUM_THREADS)
        ) u_line (
            .clk(clk), .rst(rst),
            .upd(acc_live && line_idx == LW'(g)),
            .acc_id(acc_id), .acc_thread(acc_thread), .acc_write(acc_write),
            .sector(sector),
            .inval_valid(inval_valid), .inval_id(inval_id),
            .q_rd(line_rd[g]), .q_wr(line_wr[g])
        );
    end

    assign sel_rd = line_rd[line_idx];
    assign sel_wr = line_wr[line_idx];

    always_comb begin
        tx_hits = '0;
        st_hits = '0;
        if (acc_live)
            tx_hits = (acc_write ? (sel_rd | sel_wr) : sel_wr) & others;
        if (plain_store)
            st_hits = (sel_rd | sel_wr) & live_eff;
    end

    txc_oldest_pick #(.NUM_IDS(NUM_IDS), .TS_W(TS_W)) u_pick (
        .cand(tx_hits | self_oh), .stamp(stamp), .winner(pick)
    );

    always_comb begin
        creg_n = creg_q;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (clr_valid && clr_thread == TW'(t)) creg_n[t] = '0;
            if (inval_valid) creg_n[t][inval_id] = 1'b0;
        end
        for (int b = 0; b < NUM_IDS; b++) begin
            if (tx_hits[b]) begin
                creg_n[owner[b]][acc_id] = 1'b1;
                creg_n[owner[acc_id]][b] = 1'b1;
            end
            if (st_hits[b]) creg_n[owner[b]][NUM_IDS] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            creg_q     <= '0;
            arb_valid  <= 1'b0;
            arb_winner <= '0;
        end else begin
            creg_q    <= creg_n;
            arb_valid <= |tx_hits;
            if (|tx_hits) arb_winner <= pick;
        end
    end

    assign conf_flat = creg_q;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_irq
        assign irq[t] = irq_en && (|creg_q[t]);
    end

endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_IDS     = 4,
    localparam int TW = $clog2(NUM_THREADS),
    localparam int IW = $clog2(NUM_IDS),
    localparam int CW = NUM_IDS + 1
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       irq_en,
    input logic                       acc_valid,
    input logic                       acc_txn,
    input logic                       acc_write,
    input logic                       inval_valid,
    input logic [IW-1:0]              inval_id,
    input logic                       clr_valid,
    input logic [TW-1:0]              clr_thread,
    input logic [NUM_THREADS*CW-1:0]  conf_flat,
    input logic [NUM_THREADS-1:0]     irq,
    input logic                       arb_valid
);

    assert_reset_clean_R1: assert property (@(posedge clk)
        $past(rst) |-> (conf_flat == '0 && !arb_valid));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> irq == '0);

    assert_plain_read_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_txn && !acc_write && !clr_valid && !inval_valid)
        |=> $stable(conf_flat));

    assert_arb_after_txn_R9: assert property (@(posedge clk) disable iff (rst)
        arb_valid |-> $past(acc_valid && acc_txn));

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assert_inval_withdraws_R7: assert property (@(posedge clk) disable iff (rst)
            inval_valid |=> conf_flat[t*CW + int'($past(inval_id))] == 1'b0);

        assert_clear_empties_R10: assert property (@(posedge clk) disable iff (rst)
            (clr_valid && clr_thread == TW'(t) && !acc_valid)
            |=> conf_flat[t*CW +: CW] == '0);
    end

endmodule

bind txn_conflict_detector txc_checker #(
    .NUM_THREADS(NUM_THREADS), .NUM_IDS(NUM_IDS)
) u_chk (
    .clk(clk), .rst(rst), .irq_en(irq_en),
    .acc_valid(acc_valid), .acc_txn(acc_txn), .acc_write(acc_write),
    .inval_valid(inval_valid), .inval_id(inval_id),
    .clr_valid(clr_valid), .clr_thread(clr_thread),
    .conf_flat(conf_flat), .irq(irq), .arb_valid(arb_valid)
);

// File: tb/txn_conflict_detector_tb.sv
`timescale 1ns/1ps
module txn_conflict_detector_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        irq_en;
    logic        acc_valid, acc_write, acc_txn;
    logic [1:0]  acc_thread, acc_id;
    logic [5:0]  acc_addr;
    logic        start_valid;
    logic [1:0]  start_thread, start_id;
    logic [15:0] start_time;
    logic        inval_valid;
    logic [1:0]  inval_id;
    logic        clr_valid;
    logic [1:0]  clr_thread;
    logic [19:0] conf_flat;
    logic [3:0]  irq;
    logic        arb_valid;
    logic [1:0]  arb_winner;

    int checks = 0;
    int errors = 0;
    logic       got_arb;
    logic [1:0] got_win;

    always #2.5 clk = ~clk;

    txn_conflict_detector u_dut (
        .clk(clk), .rst(rst), .irq_en(irq_en),
        .acc_valid(acc_valid), .acc_thread(acc_thread), .acc_id(acc_id),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_txn(acc_txn),
        .start_valid(start_valid), .start_thread(start_thread),
        .start_id(start_id), .start_time(start_time),
        .inval_valid(inval_valid), .inval_id(inval_id),
        .clr_valid(clr_valid), .clr_thread(clr_thread),
        .conf_flat(conf_flat), .irq(irq),
        .arb_valid(arb_valid), .arb_winner(arb_winner)
    );

    function automatic logic [4:0] reg_of(input int t);
        return conf_flat[t*5 +: 5];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step_end();
        @(negedge clk);
        acc_valid = 0; start_valid = 0; inval_valid = 0; clr_valid = 0;
        got_arb = arb_valid;
        got_win = arb_winner;
    endtask

    task automatic acc(input logic [1:0] thr, input logic [1:0] id, input logic [1:0] line,
                       input logic [3:0] sec, input logic wr, input logic txn);
        @(negedge clk);
        acc_valid = 1; acc_thread = thr; acc_id = id;
        acc_addr = {line, sec}; acc_write = wr; acc_txn = txn;
        step_end();
    endtask

    task automatic start(input logic [1:0] thr, input logic [1:0] id, input logic [15:0] ts);
        @(negedge clk);
        start_valid = 1; start_thread = thr; start_id = id; start_time = ts;
        step_end();
    endtask

    task automatic inval(input logic [1:0] id);
        @(negedge clk);
        inval_valid = 1; inval_id = id;
        step_end();
    endtask

    task automatic clr(input logic [1:0] thr);
        @(negedge clk);
        clr_valid = 1; clr_thread = thr;
        step_end();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [19:0] snap;
        rst = 1; irq_en = 1;
        acc_valid = 0; acc_thread = 0; acc_id = 0; acc_addr = 0; acc_write = 0; acc_txn = 0;
        start_valid = 0; start_thread = 0; start_id = 0; start_time = 0;
        inval_valid = 0; inval_id = 0; clr_valid = 0; clr_thread = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 conf", int'(conf_flat), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 arb", int'(arb_valid), 0);

        // R2/R5/R9/R7/R12 sweep: op pairings x same/different sector
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < 2; s++) begin
                    int hit;
                    hit = (s == 1 && (a == 1 || b == 1)) ? 1 : 0;
                    start(2'd0, 2'd0, 16'd10);
                    start(2'd1, 2'd1, 16'd20);
                    acc(2'd0, 2'd0, 2'd0, 4'd2, 1'(a), 1'b1);
                    acc(2'd1, 2'd1, 2'd0, (s == 1) ? 4'd2 : 4'd3, 1'(b), 1'b1);
                    check("R2 owner0 reg", int'(reg_of(0)), hit ? 2 : 0);
                    check("R2 owner1 reg", int'(reg_of(1)), hit ? 1 : 0);
                    check("R9 arb pulse", int'(got_arb), hit);
                    if (hit == 1) check("R9 older wins", int'(got_win), 0);
                    check("R8 irq follows reg", int'(irq[0]), hit);
                    inval(2'd0);
                    inval(2'd1);
                    check("R7 withdrawn owner0", int'(reg_of(0)), 0);
                    check("R7 withdrawn owner1", int'(reg_of(1)), 0);
                end
            end
        end

        // R3: same ID repeatedly
        start(2'd0, 2'd0, 16'd5);
        acc(2'd0, 2'd0, 2'd1, 4'd7, 1'b1, 1'b1);
        acc(2'd0, 2'd0, 2'd1, 4'd7, 1'b0, 1'b1);
        acc(2'd0, 2'd0, 2'd1, 4'd7, 1'b1, 1'b1);
        check("R3 self no conflict", int'(conf_flat), 0);
        check("R3 no arb", int'(got_arb), 0);
        inval(2'd0);

        // R4: plain accesses against a transactional read
        start(2'd0, 2'd0, 16'd10);
        acc(2'd0, 2'd0, 2'd1, 4'd3, 1'b0, 1'b1);
        acc(2'd3, 2'd3, 2'd1, 4'd3, 1'b0, 1'b0);
        check("R4 plain read quiet", int'(conf_flat), 0);
        acc(2'd3, 2'd3, 2'd1, 4'd4, 1'b1, 1'b0);
        check("R4/R5 other sector store quiet", int'(conf_flat), 0);
        acc(2'd3, 2'd3, 2'd1, 4'd3, 1'b1, 1'b0);
        check("R4 plain store flagged", int'(reg_of(0)), 16);
        check("R8 irq raised", int'(irq), 1);
        @(negedge clk); irq_en = 0; #1;
        check("R8 irq masked", int'(irq), 0);
        check("R8 reg kept when masked", int'(reg_of(0)), 16);
        irq_en = 1;
        clr(2'd0);
        check("R10 cleared", int'(reg_of(0)), 0);
        check("R10 irq low", int'(irq), 0);
        inval(2'd0);

        // R6: third thread coarsens line 2
        start(2'd0, 2'd0, 16'd10);
        start(2'd1, 2'd1, 16'd20);
        start(2'd2, 2'd2, 16'd30);
        acc(2'd0, 2'd0, 2'd2, 4'd0, 1'b0, 1'b1);
        acc(2'd1, 2'd1, 2'd2, 4'd1, 1'b0, 1'b1);
        acc(2'd2, 2'd2, 2'd2, 4'd9, 1'b0, 1'b1);
        check("R6 reads only", int'(conf_flat), 0);
        acc(2'd1, 2'd1, 2'd2, 4'd5, 1'b1, 1'b1);
        check("R6 half conflict owner0", int'(reg_of(0)), 2);
        check("R6 half conflict owner1", int'(reg_of(1)), 1);
        check("R6 other half clean", int'(reg_of(2)), 0);
        check("R9 winner id0", int'(got_win), 0);

        // R7: invalidate id0 mid-conflict
        inval(2'd0);
        check("R7 owner1 bit0 gone", int'(reg_of(1)), 0);
        check("R7 owner0 keeps bit1", int'(reg_of(0)), 2);
        acc(2'd2, 2'd2, 2'd2, 4'd0, 1'b1, 1'b1);
        check("R7 store meets id1 only", int'(reg_of(2)), 2);
        check("R7 owner1 sees id2", int'(reg_of(1)), 4);
        check("R9 winner id1", int'(got_win), 1);

        // R11: unstarted ID is ignored
        snap = conf_flat;
        acc(2'd3, 2'd3, 2'd2, 4'd0, 1'b1, 1'b1);
        check("R11 regs unchanged", int'(conf_flat), int'(snap));
        check("R11 no arb", int'(got_arb), 0);
        acc(2'd3, 2'd3, 2'd2, 4'd2, 1'b1, 1'b1);
        check("R11 still unchanged", int'(conf_flat), int'(snap));

        // R9 tie, lower ID wins
        inval(2'd1);
        inval(2'd2);
        for (int t = 0; t < 4; t++) clr(2'(t));
        check("R10 all clear", int'(conf_flat), 0);
        start(2'd2, 2'd2, 16'd50);
        start(2'd3, 2'd3, 16'd50);
        acc(2'd3, 2'd3, 2'd3, 4'd2, 1'b1, 1'b1);
        acc(2'd2, 2'd2, 2'd3, 4'd2, 1'b0, 1'b1);
        check("R9 tie pulse", int'(got_arb), 1);
        check("R9 tie lower id", int'(got_win), 2);

        // R12: line 2 emptied, back to sector tracking
        start(2'd0, 2'd0, 16'd60);
        start(2'd1, 2'd1, 16'd70);
        acc(2'd0, 2'd0, 2'd2, 4'd0, 1'b0, 1'b1);
        acc(2'd1, 2'd1, 2'd2, 4'd1, 1'b1, 1'b1);
        check("R12 fine again owner0", int'(reg_of(0)), 0);
        check("R12 fine again owner1", int'(reg_of(1)), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule